// File: doc/BRIEF.md
# TTY Buffer Transfer Engine

This block carries out the two bulk commands of a character terminal peripheral. Software programs a 64-bit buffer address and a 32-bit byte count through three register write strobes, then strobes a command. The transmit command fetches the programmed number of bytes from memory over a byte-wide request/response port and hands each one to a transmit byte stream. The receive command moves bytes from a receive FIFO into memory. It stops as soon as the count is used up or the FIFO runs dry, and any count left over is dropped.

The engine works on private running copies of the address and count, so the programmed values are still there for the next command. Only one command runs at a time. A `done` pulse marks the end of every command, including commands that do nothing. At the end of a receive that leaves the FIFO empty while interrupts are enabled, `irq_drop` pulses together with `done`, so that the interrupt logic outside the block can lower its line.

The controller has six states. `ST_IDLE` waits for a start. `ST_TX_REQ` issues a read request. `ST_TX_WAIT` waits for the read response and captures it. `ST_TX_SEND` offers the captured byte to the stream. `ST_RX_MOVE` offers the FIFO head as a memory write. `ST_FINISH` is the one-cycle completion state.

The transitions are as follows. A start in `ST_IDLE` goes to `ST_TX_REQ` for a transmit with a nonzero count, to `ST_RX_MOVE` for a receive with a nonzero count and a non-empty FIFO, and to `ST_FINISH` in every other case. `ST_TX_REQ` goes to `ST_TX_WAIT` when the request is accepted. `ST_TX_WAIT` goes to `ST_TX_SEND` when the response arrives. `ST_TX_SEND` goes back to `ST_TX_REQ` when the stream accepts the byte, or to `ST_FINISH` if that was the last byte. `ST_RX_MOVE` stays in place for each accepted write, and goes to `ST_FINISH` on its last byte or when the FIFO is empty. `ST_FINISH` always returns to `ST_IDLE`.

Top module: `tty_xfer_engine`

## Requirements
- R1: A pulse on `ptr_lo_wr` sets the whole 64-bit buffer address to `reg_wdata` zero-extended, which clears bits 63:32.
- R2: A pulse on `ptr_hi_wr` sets bits 63:32 of the buffer address to `reg_wdata` and leaves bits 31:0 unchanged. A pulse on `len_wr` sets the byte count to `reg_wdata`.
- R3: Command code 2 (transmit) with count N>0 issues exactly N read requests (`mem_req_write`=0) at addresses P, P+1, …, P+N-1. Each response byte appears on `tx_data`, in order.
- R4: A read response is held on `tx_data` with `tx_valid` high until `tx_ready` is seen. No byte is lost or repeated, whatever the request or stream backpressure.
- R5: Command code 3 (receive) with count N>0 issues write requests (`mem_req_write`=1) whose `mem_wdata` is the FIFO head, at addresses P, P+1, and so on. `fifo_pop` is asserted with each accepted write. The command ends after N bytes or as soon as the FIFO is empty, whichever comes first.
- R6: `irq_drop` is high in the `done` cycle of a receive exactly when `irq_en` is 1 and `fifo_empty` is 1 in that cycle. It is low at every other time.
- R7: A transmit or receive with a count of 0 raises `done` in the cycle after the start strobe, with no memory, stream or FIFO activity.
- R8: Any command code other than 2 or 3 raises `done` in the cycle after the start strobe, with no memory, stream or FIFO activity.
- R9: A start strobe that arrives while `busy` is high is ignored: it produces no extra `done` and no FIFO or memory activity.
- R10: `done` is high for exactly one cycle per command. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R11: The running address advances by one per byte in 64-bit arithmetic, wrapping from all-ones to zero.
- R12: A transfer does not change the programmed address or count, so repeating a command without new register writes reproduces the same address sequence.
- R13: After reset the address and count are 0, `busy`, `done`, `irq_drop`, `mem_req_valid`, `tx_valid` and `fifo_pop` are low, and an idle engine drives no request, stream byte or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_lo_wr | input | 1 | Write the low address word, clearing the high word |
| ptr_hi_wr | input | 1 | Write the high address word only |
| len_wr | input | 1 | Write the byte count |
| reg_wdata | input | REG_W | Register write value |
| start | input | 1 | Command strobe |
| cmd | input | CMD_W | Command code (2 transmit, 3 receive) |
| irq_en | input | 1 | Interrupt enable state from the interrupt logic |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 2*REG_W | Byte address |
| mem_wdata | output | DATA_W | Write byte |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DATA_W | Read response byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit stream ready |
| tx_data | output | DATA_W | Transmit byte |
| fifo_empty | input | 1 | Receive FIFO empty |
| fifo_data | input | DATA_W | Receive FIFO head byte |
| fifo_pop | output | 1 | Remove FIFO head |
| done | output | 1 | Command complete pulse |
| busy | output | 1 | Command in progress |
| irq_drop | output | 1 | Request to lower the interrupt line |

## Verification
The bench builds the engine with a 32-bit register word, and therefore a 64-bit address, and with an 8-bit command code. With this width the address can be programmed to all-ones minus one through the two address strobes, which brings the 64-bit carry out, and its wrap to zero, within a three-byte transfer. The 8-bit command field also lets unused codes above 3 be tried alongside 0 and 1. Request and stream stalls and a read latency of up to three cycles are run against the same address to expose a held or repeated byte.

// File: rtl/tty_xfer_pkg.sv
package tty_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_REQ,
        ST_TX_WAIT,
        ST_TX_SEND,
        ST_RX_MOVE,
        ST_FINISH
    } xfer_state_t;

    localparam int unsigned CODE_TX = 2;
    localparam int unsigned CODE_RX = 3;

endpackage

// File: rtl/tty_xfer_regs.sv
module tty_xfer_regs #(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ptr_lo_wr,
    input  logic               ptr_hi_wr,
    input  logic               len_wr,
    input  logic [REG_W-1:0]   wdata,
    output logic [2*REG_W-1:0] ptr_q,
    output logic [REG_W-1:0]   len_q
);

    // low write clears the high word; a high write keeps the low word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= '0;
        end else begin
            if (ptr_lo_wr && ptr_hi_wr) begin
                ptr_q <= {wdata, wdata};
            end else if (ptr_lo_wr) begin
                ptr_q <= {{REG_W{1'b0}}, wdata};
            end else if (ptr_hi_wr) begin
                ptr_q <= {wdata, ptr_q[REG_W-1:0]};
            end
            if (len_wr) begin
                len_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/tty_xfer_cursor.sv
module tty_xfer_cursor #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= ptr_in;
            remain <= len_in;
        end else if (step) begin
            addr   <= addr + ADDR_ONE;
            remain <= remain - LEN_ONE;
        end
    end

    assign last = (remain == LEN_ONE);

endmodule

// File: rtl/tty_xfer_fsm.sv
module tty_xfer_fsm
    import tty_xfer_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             len_zero,
    input  logic             last,
    input  logic             irq_en,
    input  logic             fifo_empty,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic             tx_ready,
    output logic             load,
    output logic             step,
    output logic             hold_en,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic             tx_valid,
    output logic             fifo_pop,
    output logic             done,
    output logic             busy,
    output logic             irq_drop
);

    xfer_state_t state, nxt;
    logic        rx_mode;
    logic        is_tx, is_rx;

    assign is_tx = (cmd == CMD_W'(CODE_TX));
    assign is_rx = (cmd == CMD_W'(CODE_RX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rx_mode <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                rx_mode <= is_rx;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (is_tx) begin
                        nxt = len_zero ? ST_FINISH : ST_TX_REQ;
                    end else if (is_rx) begin
                        nxt = (len_zero || fifo_empty) ? ST_FINISH : ST_RX_MOVE;
                    end else begin
                        nxt = ST_FINISH;
                    end
                end
            end
            ST_TX_REQ:  if (mem_req_ready) nxt = ST_TX_WAIT;
            ST_TX_WAIT: if (mem_rsp_valid) nxt = ST_TX_SEND;
            ST_TX_SEND: if (tx_ready) nxt = last ? ST_FINISH : ST_TX_REQ;
            ST_RX_MOVE: begin
                if (fifo_empty) begin
                    nxt = ST_FINISH;
                end else if (mem_req_ready && last) begin
                    nxt = ST_FINISH;
                end
            end
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load          = (state == ST_IDLE) && start;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        tx_valid      = 1'b0;
        fifo_pop      = 1'b0;
        hold_en       = 1'b0;
        step          = 1'b0;
        done          = 1'b0;
        irq_drop      = 1'b0;
        busy          = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: ;
            ST_TX_REQ: mem_req_valid = 1'b1;
            ST_TX_WAIT: hold_en = mem_rsp_valid;
            ST_TX_SEND: begin
                tx_valid = 1'b1;
                step     = tx_ready;
            end
            ST_RX_MOVE: begin
                mem_req_write = 1'b1;
                mem_req_valid = !fifo_empty;
                fifo_pop      = !fifo_empty && mem_req_ready;
                step          = !fifo_empty && mem_req_ready;
            end
            ST_FINISH: begin
                done     = 1'b1;
                irq_drop = rx_mode && irq_en && fifo_empty;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tty_xfer_engine.sv
module tty_xfer_engine #(
    parameter int REG_W  = 32,
    parameter int CMD_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_lo_wr,
    input  logic                ptr_hi_wr,
    input  logic                len_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                start,
    input  logic [CMD_W-1:0]    cmd,
    input  logic                irq_en,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [2*REG_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_data,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic [DATA_W-1:0]   tx_data,
    input  logic                fifo_empty,
    input  logic [DATA_W-1:0]   fifo_data,
    output logic                fifo_pop,
    output logic                done,
    output logic                busy,
    output logic                irq_drop
);

    localparam int ADDR_W = 2 * REG_W;
    localparam int LEN_W  = REG_W;

    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic              load, step, last, hold_en;
    logic [DATA_W-1:0] hold_q;

    tty_xfer_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_lo_wr (ptr_lo_wr),
        .ptr_hi_wr (ptr_hi_wr),
        .len_wr    (len_wr),
        .wdata     (reg_wdata),
        .ptr_q     (ptr_q),
        .len_q     (len_q)
    );

    tty_xfer_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cursor (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .ptr_in (ptr_q),
        .len_in (len_q),
        .step   (step),
        .addr   (mem_addr),
        .last   (last)
    );

    tty_xfer_fsm #(.CMD_W(CMD_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cmd           (cmd),
        .len_zero      (len_q == '0),
        .last          (last),
        .irq_en        (irq_en),
        .fifo_empty    (fifo_empty),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .tx_ready      (tx_ready),
        .load          (load),
        .step          (step),
        .hold_en       (hold_en),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .tx_valid      (tx_valid),
        .fifo_pop      (fifo_pop),
        .done          (done),
        .busy          (busy),
        .irq_drop      (irq_drop)
    );

    // read response is kept here until the stream takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_en) begin
            hold_q <= mem_rsp_data;
        end
    end

    assign tx_data   = hold_q;
    assign mem_wdata = mem_req_write ? fifo_data : '0;

endmodule

// File: rtl/tty_xfer_engine_sva.sv
module tty_xfer_engine_sva #(
    parameter int REG_W  = 32,
    parameter int CMD_W  = 8,
    parameter int DATA_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [CMD_W-1:0]   cmd,
    input logic               irq_en,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_write,
    input logic [2*REG_W-1:0] mem_addr,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [DATA_W-1:0]  tx_data,
    input logic               fifo_empty,
    input logic               fifo_pop,
    input logic               done,
    input logic               busy,
    input logic               irq_drop
);

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !tx_valid && !fifo_pop && !done));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && !mem_req_ready)
        |=> (mem_req_valid && !mem_req_write && $stable(mem_addr)));

    p_pop_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!fifo_empty && mem_req_valid && mem_req_write && mem_req_ready));

    p_drop_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drop |-> (done && irq_en && fifo_empty));

    p_other_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd != CMD_W'(2) && cmd != CMD_W'(3)) |=> done);

endmodule

bind tty_xfer_engine tty_xfer_engine_sva #(
    .REG_W(REG_W), .CMD_W(CMD_W), .DATA_W(DATA_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cmd           (cmd),
    .irq_en        (irq_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_addr      (mem_addr),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .fifo_empty    (fifo_empty),
    .fifo_pop      (fifo_pop),
    .done          (done),
    .busy          (busy),
    .irq_drop      (irq_drop)
);

// File: tb/tty_xfer_engine_tb.sv
module tty_xfer_engine_tb;

    localparam int REG_W  = 32;
    localparam int CMD_W  = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ptr_lo_wr = 1'b0, ptr_hi_wr = 1'b0, len_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic              start = 1'b0;
    logic [7:0]        cmd = '0;
    logic              irq_en = 1'b0;
    logic              mem_req_valid, mem_req_write;
    logic              mem_req_ready = 1'b1;
    logic [63:0]       mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [7:0]        mem_rsp_data = '0;
    logic              tx_valid;
    logic              tx_ready = 1'b1;
    logic [7:0]        tx_data;
    logic              fifo_empty = 1'b1;
    logic [7:0]        fifo_data = '0;
    logic              fifo_pop, done, busy, irq_drop;

    always #4 clk = ~clk;

    tty_xfer_engine #(.REG_W(REG_W), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ptr_lo_wr(ptr_lo_wr), .ptr_hi_wr(ptr_hi_wr),
        .len_wr(len_wr), .reg_wdata(reg_wdata), .start(start), .cmd(cmd),
        .irq_en(irq_en), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .done(done), .busy(busy), .irq_drop(irq_drop)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    bit stall_mem = 0, stall_tx = 0;
    int rsp_lat = 1;
    byte unsigned fifo_q[$];
    logic [63:0] exp_rd[$], exp_wr_a[$];
    logic [7:0]  exp_wr_d[$], exp_tx[$];
    int n_rd = 0, n_wr = 0, n_tx = 0, n_pop = 0, n_done = 0, n_drop = 0;
    bit pend_pop = 0, rd_pending = 0;
    int rd_delay = 0;
    logic [63:0] rd_addr_l = '0;
    logic [63:0] ptr_m = '0;
    logic [31:0] len_m = '0;

    function automatic logic [7:0] memval(logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // environment: memory, stream sink, FIFO, per-clock comparison
    initial begin
        forever begin
            @(negedge clk);
            if (pend_pop) begin
                if (fifo_q.size() > 0) void'(fifo_q.pop_front());
                pend_pop = 0;
            end
            cyc++;
            mem_req_ready = stall_mem ? (cyc % 3 != 1) : 1'b1;
            tx_ready      = stall_tx ? ((cyc % 4) < 2) : 1'b1;
            mem_rsp_valid = 1'b0;
            if (rd_pending) begin
                if (rd_delay <= 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memval(rd_addr_l);
                    rd_pending    = 0;
                end else begin
                    rd_delay--;
                end
            end
            fifo_empty = (fifo_q.size() == 0);
            fifo_data  = fifo_empty ? 8'h00 : fifo_q[0];
            #1;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    n_wr++;
                    if (exp_wr_a.size() == 0) chk("R5", "unexpected write", mem_addr, '1);
                    else begin
                        chk("R5", "write address", mem_addr, exp_wr_a.pop_front());
                        chk("R5", "write data", {56'h0, mem_wdata}, {56'h0, exp_wr_d.pop_front()});
                    end
                end else begin
                    n_rd++;
                    if (exp_rd.size() == 0) chk("R3", "unexpected read", mem_addr, '1);
                    else chk("R3", "read address", mem_addr, exp_rd.pop_front());
                    rd_pending = 1;
                    rd_delay   = rsp_lat - 1;
                    rd_addr_l  = mem_addr;
                end
            end
            if (fifo_pop) begin
                n_pop++;
                pend_pop = 1;
            end
            if (tx_valid && tx_ready) begin
                n_tx++;
                if (exp_tx.size() == 0) chk("R4", "unexpected tx byte", {56'h0, tx_data}, '1);
                else chk("R4", "tx byte", {56'h0, tx_data}, {56'h0, exp_tx.pop_front()});
            end
            if (done) n_done++;
            if (irq_drop) n_drop++;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wr_lo(logic [31:0] v);
        @(negedge clk); ptr_lo_wr = 1; reg_wdata = v;
        @(negedge clk); ptr_lo_wr = 0;
        ptr_m = {32'h0, v};
    endtask

    task automatic wr_hi(logic [31:0] v);
        @(negedge clk); ptr_hi_wr = 1; reg_wdata = v;
        @(negedge clk); ptr_hi_wr = 0;
        ptr_m[63:32] = v;
    endtask

    task automatic wr_len(logic [31:0] v);
        @(negedge clk); len_wr = 1; reg_wdata = v;
        @(negedge clk); len_wr = 0;
        len_m = v;
    endtask

    task automatic expect_tx();
        for (int i = 0; i < int'(len_m); i++) begin
            exp_rd.push_back(ptr_m + 64'(i));
            exp_tx.push_back(memval(ptr_m + 64'(i)));
        end
    endtask

    task automatic expect_rx();
        int n;
        n = (int'(len_m) < fifo_q.size()) ? int'(len_m) : fifo_q.size();
        for (int i = 0; i < n; i++) begin
            exp_wr_a.push_back(ptr_m + 64'(i));
            exp_wr_d.push_back(fifo_q[i]);
        end
    endtask

    task automatic launch(logic [7:0] c);
        @(negedge clk); start = 1; cmd = c;
        @(negedge clk); start = 0;
    endtask

    // returns number of extra cycles waited after the launch ended
    task automatic wait_done(input int base, output int waited);
        waited = 0;
        #2;
        while (n_done == base && waited < 2000) begin
            @(negedge clk); #2;
            waited++;
        end
    endtask

    task automatic finish_cmd(string req, int base);
        chk(req, "done count", n_done, base + 1);
        @(negedge clk); #2;
        chk("R10", "done low after pulse", {63'h0, done}, 64'h0);
        chk("R10", "busy low after done", {63'h0, busy}, 64'h0);
        chk(req, "reads left", exp_rd.size(), 0);
        chk(req, "tx left", exp_tx.size(), 0);
        chk(req, "writes left", exp_wr_a.size(), 0);
    endtask

    task automatic run_tx(string req);
        int base, w;
        base = n_done;
        expect_tx();
        launch(8'd2);
        #1;
        chk("R10", "busy after start", {63'h0, busy}, 64'h1);
        wait_done(base, w);
        finish_cmd(req, base);
    endtask

    task automatic run_rx(string req);
        int base, w;
        base = n_done;
        expect_rx();
        launch(8'd3);
        wait_done(base, w);
        finish_cmd(req, base);
    endtask

    task automatic run_quiet(string req, logic [7:0] c);
        int base, w, a0, a1, a2, a3;
        base = n_done; a0 = n_rd; a1 = n_wr; a2 = n_tx; a3 = n_pop;
        launch(c);
        wait_done(base, w);
        chk(req, "done in cycle after start", w, 0);
        chk(req, "no activity", (n_rd - a0) + (n_wr - a1) + (n_tx - a2) + (n_pop - a3), 0);
        finish_cmd(req, base);
    endtask

    initial begin
        int base, w, fs, d0;
        repeat (3) @(negedge clk);
        #2;
        chk("R13", "busy at reset", {63'h0, busy}, 64'h0);
        chk("R13", "done at reset", {63'h0, done}, 64'h0);
        chk("R13", "req at reset", {63'h0, mem_req_valid}, 64'h0);
        chk("R13", "tx at reset", {63'h0, tx_valid}, 64'h0);
        chk("R13", "pop at reset", {63'h0, fifo_pop}, 64'h0);
        @(negedge clk); rst_n = 1;

        // reset count is zero: transmit completes at once (R13, R7)
        run_quiet("R7", 8'd2);

        // high word kept across high write (R2), basic transmit (R3)
        wr_lo(32'h0000_1000);
        wr_hi(32'h0000_ABCD);
        wr_len(32'd5);
        run_tx("R3");

        // same command again under stalls and slow responses (R4, R12)
        stall_mem = 1; stall_tx = 1; rsp_lat = 3;
        run_tx("R12");
        stall_mem = 0; stall_tx = 0; rsp_lat = 1;

        // low write clears the high word (R1)
        wr_lo(32'h0000_0020);
        wr_len(32'd4);
        run_tx("R1");

        // start while busy is ignored (R9)
        fifo_q = '{8'h11, 8'h22};
        stall_tx = 1; stall_mem = 1;
        base = n_done; d0 = n_wr;
        expect_tx();
        launch(8'd2);
        @(negedge clk); start = 1; cmd = 8'd3;
        @(negedge clk); start = 0;
        wait_done(base, w);
        finish_cmd("R9", base);
        repeat (5) @(negedge clk);
        #2;
        chk("R9", "no extra done", n_done, base + 1);
        chk("R9", "fifo untouched", fifo_q.size(), 2);
        chk("R9", "no writes", n_wr - d0, 0);
        stall_tx = 0; stall_mem = 0;
        fifo_q = {};
        repeat (2) @(negedge clk);

        // 64-bit wrap (R11)
        wr_lo(32'hFFFF_FFFE);
        wr_hi(32'hFFFF_FFFF);
        wr_len(32'd3);
        run_tx("R11");

        // receive limited by count, FIFO left non-empty (R5, R6)
        fifo_q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35};
        irq_en = 1;
        stall_mem = 1;
        wr_lo(32'h0000_0400);
        wr_len(32'd3);
        d0 = n_drop;
        run_rx("R5");
        chk("R5", "fifo left", fifo_q.size(), 2);
        chk("R6", "no drop with fifo non-empty", n_drop - d0, 0);

        // receive stops early when FIFO empties (R5, R6)
        wr_len(32'd10);
        d0 = n_drop;
        run_rx("R5");
        chk("R5", "fifo drained", fifo_q.size(), 0);
        chk("R6", "drop with irq enabled", n_drop - d0, 1);
        stall_mem = 0;

        // interrupts disabled: no drop (R6)
        irq_en = 0;
        fifo_q = '{8'h77};
        wr_len(32'd1);
        d0 = n_drop;
        run_rx("R6");
        chk("R6", "no drop with irq disabled", n_drop - d0, 0);

        // zero count receive with data waiting (R7)
        fifo_q = '{8'h55};
        wr_len(32'd0);
        fs = fifo_q.size();
        run_quiet("R7", 8'd3);
        chk("R7", "fifo untouched", fifo_q.size(), fs);

        // unhandled codes (R8)
        wr_len(32'd4);
        run_quiet("R8", 8'd0);
        run_quiet("R8", 8'd1);
        run_quiet("R8", 8'd7);
        chk("R8", "fifo untouched", fifo_q.size(), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule